// File: doc/BRIEF.md
# Serial Panel Register Command Writer

This block sends single register writes to a display panel controller over a three-line serial link made of an active-low select, a shift clock and a data line. A client hands it an 8-bit register address and an 8-bit value with a one-cycle request. The block packs them into a 16-bit word, address in the upper byte, and shifts the word out most significant bit first. The panel captures each bit on the rising edge of the shift clock. Between frames the select and the clock both rest high.

The block also holds a small sequencer with two built-in command lists. One is a five-write list that powers the display on. The other is a single write that turns the display off. Either list starts from a one-cycle pulse. The sequencer feeds its words to the same frame engine that serves direct requests, one frame after another, with a fixed idle stretch between frames. Every phase of the serial link, meaning the lead-in, the select setup, and each low or high half of the clock, lasts `HALF_CYC` system clocks.

The design has four parts. A phase timer produces the half-period tick. A frame engine state machine has the states IDLE, LEAD, SELECT, CLK_LO and CLK_HI. It moves IDLE->LEAD on a start, LEAD->SELECT, SELECT->CLK_LO, CLK_LO->CLK_HI, CLK_HI->CLK_LO while bits remain, and CLK_HI->IDLE after the sixteenth bit; every move except the start waits for a tick. A sequencer state machine has the states Q_IDLE, Q_ISSUE, Q_WAIT and Q_GAP. It moves Q_IDLE->Q_ISSUE on an accepted list pulse, Q_ISSUE->Q_WAIT at once, Q_WAIT->Q_GAP or Q_WAIT->Q_IDLE when a frame ends, and Q_GAP->Q_ISSUE after one tick. The top module accepts requests and arbitrates between them.

Top module: `panel_cmd_writer`

## Requirements
- R1: After reset, `sen_n` and `sclk` are high, `busy` is low and `sdata` is low.
- R2: A frame opens with `sdata` low while `sen_n` is still high. `sen_n` then falls while `sclk` is high. When the frame ends, `sen_n` rises while `sclk` is high.
- R3: Each frame carries exactly 16 rising `sclk` edges. The bits captured on them, in order, equal `{addr, val}`: the address occupies bits 15..8 and is sent first, and bit 15 is the first bit on the wire.
- R4: `sdata` changes only while `sclk` is low. It holds one value through each low half and through the high half that follows it.
- R5: Within a frame, each low half and each high half of `sclk` lasts exactly `HALF_CYC` system clocks. The select setup, from the fall of `sen_n` to the first low of `sclk`, also lasts `HALF_CYC` system clocks.
- R6: `busy` rises in the cycle after a request is accepted. It falls in the same cycle that `sen_n` returns high. For one direct write it stays high for 34*`HALF_CYC` cycles.
- R7: A `req`, `seq_on` or `seq_off` pulse that arrives while `busy` is high has no effect. No extra frame is ever sent because of it.
- R8: A `seq_on` pulse sends five writes as (address, value) pairs, in this order: (0x05,0x1E), (0x05,0x5E), (0x07,0x8D), (0x13,0x01), (0x05,0x5F).
- R9: A `seq_off` pulse sends the single write (0x05,0x5E).
- R10: Between consecutive frames of one list, `sen_n` stays high for exactly 2*`HALF_CYC`+1 system clocks. `busy` stays high from acceptance until the last frame ends: 5*(34*`HALF_CYC`+1)+4*`HALF_CYC` cycles for the on list, and 34*`HALF_CYC`+1 cycles for the off list.
- R11: When more than one start input is high in the same idle cycle, `seq_on` wins over `seq_off`, and `seq_off` wins over `req`. The inputs that lose are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle request for a direct write |
| addr | input | 8 | Register address for a direct write |
| val | input | 8 | Register value for a direct write |
| seq_on | input | 1 | One-cycle pulse that starts the display-on list |
| seq_off | input | 1 | One-cycle pulse that starts the display-off write |
| busy | output | 1 | High while a write or a list is in progress |
| sen_n | output | 1 | Serial select, active low |
| sclk | output | 1 | Serial shift clock; the panel samples on its rising edge |
| sdata | output | 1 | Serial data, most significant bit first |

## Verification
The bench builds the block with `HALF_CYC` = 3. This value is odd and not a power of two. With it, an off-by-one error in the phase counter shows up as a half-period of 2 or 4 clocks, a busy count other than 102, or a list gap other than 7. The three-clock halves also give room to see whether `sdata` moves during a high half or at a clock edge. The run includes a full on list, which lets the 527-cycle busy window and the four inter-frame gaps be measured end to end.

// File: rtl/panel_wr_pkg.sv
package panel_wr_pkg;

    localparam int WORD_W    = 16;
    localparam int IDX_W     = 3;
    localparam int ON_FIRST  = 0;
    localparam int ON_LAST   = 4;
    localparam int OFF_INDEX = 5;

    typedef enum logic [2:0] {
        F_IDLE,
        F_LEAD,
        F_SELECT,
        F_CLK_LO,
        F_CLK_HI
    } frame_state_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_ISSUE,
        Q_WAIT,
        Q_GAP
    } seq_state_e;

    // Built-in command words: entries 0..4 form the power-up list,
    // entry 5 is the power-down write.
    function automatic logic [WORD_W-1:0] list_word(input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] w;
        unique case (idx)
            3'd0:    w = 16'h051E;
            3'd1:    w = 16'h055E;
            3'd2:    w = 16'h078D;
            3'd3:    w = 16'h1301;
            3'd4:    w = 16'h055F;
            3'd5:    w = 16'h055E;
            default: w = 16'h0000;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/panel_phase_timer.sv
module panel_phase_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == TOP);
endmodule

// File: rtl/panel_frame_engine.sv
module panel_frame_engine
    import panel_wr_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              done,
    output logic              sen_n,
    output logic              sclk,
    output logic              sdata
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    frame_state_e      state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [BIT_W-1:0]  bit_cnt;
    logic              tick;

    panel_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != F_IDLE),
        .tick  (tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            F_IDLE:   if (start) state_nx = F_LEAD;
            F_LEAD:   if (tick)  state_nx = F_SELECT;
            F_SELECT: if (tick)  state_nx = F_CLK_LO;
            F_CLK_LO: if (tick)  state_nx = F_CLK_HI;
            F_CLK_HI: if (tick)  state_nx = (bit_cnt == LAST_BIT) ? F_IDLE : F_CLK_LO;
            default:             state_nx = F_IDLE;
        endcase
    end

    // Shift data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (state == F_IDLE && start) begin
            shreg   <= word;
            bit_cnt <= '0;
        end else if (state == F_CLK_HI && tick) begin
            shreg   <= {shreg[WORD_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        sen_n = 1'b1;
        sclk  = 1'b1;
        sdata = 1'b0;
        unique case (state)
            F_IDLE, F_LEAD: ;
            F_SELECT: sen_n = 1'b0;
            F_CLK_LO: begin
                sen_n = 1'b0;
                sclk  = 1'b0;
                sdata = shreg[WORD_W-1];
            end
            F_CLK_HI: begin
                sen_n = 1'b0;
                sdata = shreg[WORD_W-1];
            end
            default: ;
        endcase
    end

    assign busy = (state != F_IDLE);
    assign done = (state == F_CLK_HI) && tick && (bit_cnt == LAST_BIT);
endmodule

// File: rtl/panel_power_sequencer.sv
module panel_power_sequencer
    import panel_wr_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_on,
    input  logic              go_off,
    input  logic              frame_done,
    output logic              issue,
    output logic [WORD_W-1:0] issue_word,
    output logic              active
);
    seq_state_e       state, state_nx;
    logic [IDX_W-1:0] idx, last_idx;
    logic             gap_tick;

    panel_phase_timer #(.HALF_CYC(HALF_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == Q_GAP),
        .tick  (gap_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_IDLE:  if (go_on || go_off) state_nx = Q_ISSUE;
            Q_ISSUE: state_nx = Q_WAIT;
            Q_WAIT:  if (frame_done) state_nx = (idx == last_idx) ? Q_IDLE : Q_GAP;
            Q_GAP:   if (gap_tick) state_nx = Q_ISSUE;
            default: state_nx = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            last_idx <= '0;
        end else if (state == Q_IDLE && go_on) begin
            idx      <= IDX_W'(ON_FIRST);
            last_idx <= IDX_W'(ON_LAST);
        end else if (state == Q_IDLE && go_off) begin
            idx      <= IDX_W'(OFF_INDEX);
            last_idx <= IDX_W'(OFF_INDEX);
        end else if (state == Q_GAP && gap_tick) begin
            idx <= idx + 1'b1;
        end
    end

    assign issue      = (state == Q_ISSUE);
    assign issue_word = list_word(idx);
    assign active     = (state != Q_IDLE);
endmodule

// File: rtl/panel_cmd_writer.sv
module panel_cmd_writer
    import panel_wr_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [7:0] addr,
    input  logic [7:0] val,
    input  logic       seq_on,
    input  logic       seq_off,
    output logic       busy,
    output logic       sen_n,
    output logic       sclk,
    output logic       sdata
);
    logic              eng_busy, eng_done, seq_active, seq_issue;
    logic [WORD_W-1:0] seq_word, eng_word;
    logic              idle, go_on, go_off, go_direct, eng_start;

    // Arbitration: the on list first, then the off write, then a direct write
    assign idle      = !eng_busy && !seq_active;
    assign go_on     = idle && seq_on;
    assign go_off    = idle && !seq_on && seq_off;
    assign go_direct = idle && !seq_on && !seq_off && req;

    assign eng_start = go_direct || seq_issue;
    assign eng_word  = seq_issue ? seq_word : {addr, val};

    panel_power_sequencer #(.HALF_CYC(HALF_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_on      (go_on),
        .go_off     (go_off),
        .frame_done (eng_done),
        .issue      (seq_issue),
        .issue_word (seq_word),
        .active     (seq_active)
    );

    panel_frame_engine #(.HALF_CYC(HALF_CYC)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .word  (eng_word),
        .busy  (eng_busy),
        .done  (eng_done),
        .sen_n (sen_n),
        .sclk  (sclk),
        .sdata (sdata)
    );

    assign busy = eng_busy || seq_active;
endmodule

// File: rtl/panel_cmd_writer_checker.sv
module panel_cmd_writer_checker #(
    parameter int HALF_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic seq_on,
    input logic seq_off,
    input logic busy,
    input logic sen_n,
    input logic sclk,
    input logic sdata
);
    logic [15:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lo_run <= '0;
        else if (sclk) lo_run <= '0;
        else           lo_run <= lo_run + 1'b1;
    end

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sen_n && sclk)); // R1

    AST_LEAD_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sen_n) |-> !sdata); // R2

    AST_SEN_EDGE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sen_n) || $rose(sen_n)) |-> sclk); // R2

    AST_CLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> !sen_n); // R3

    AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && !sen_n && !$past(sen_n)) |-> $stable(sdata)); // R4

    AST_LOW_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_run == 16'(HALF_CYC))); // R5

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (req || seq_on || seq_off)) |=> busy); // R6

    AST_SELECT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_n |-> busy); // R6
endmodule

bind panel_cmd_writer panel_cmd_writer_checker #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .seq_on  (seq_on),
    .seq_off (seq_off),
    .busy    (busy),
    .sen_n   (sen_n),
    .sclk    (sclk),
    .sdata   (sdata)
);

// File: tb/panel_cmd_writer_bench.sv
module panel_cmd_writer_bench;
    localparam int H        = 3;
    localparam int FRAME    = 34 * H;
    localparam int LIST_GAP = 2 * H + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, seq_on = 1'b0, seq_off = 1'b0;
    logic [7:0] addr = '0, val = '0;
    logic       busy, sen_n, sclk, sdata;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    typedef struct {
        logic [15:0] w;
        string       tag;
        int          gap;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    panel_cmd_writer #(.HALF_CYC(H)) u_panel_cmd_writer (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .val(val),
        .seq_on(seq_on), .seq_off(seq_off), .busy(busy),
        .sen_n(sen_n), .sclk(sclk), .sdata(sdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] w, input string tag, input int gap);
        exp_t e;
        e.w = w; e.tag = tag; e.gap = gap;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Drive one start cycle and count how long busy stays high
    task automatic kick(input logic r, input logic on, input logic off,
                        input logic [7:0] a, input logic [7:0] v, output int n);
        wait_idle();
        req = r; seq_on = on; seq_off = off; addr = a; val = v;
        @(negedge clk);
        req = 0; seq_on = 0; seq_off = 0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Monitor: rebuild each frame from the pins and score it
    bit          p_sen = 1, p_sclk = 1, in_frame = 0;
    int          nbits, lo_len, hi_len, gap_len;
    logic [15:0] acc;
    logic        lo_data;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_sen && !sen_n) begin
                chk(sdata == 1'b0, "R2 data low at select", sdata, 0);
                chk(sclk == 1'b1, "R2 clock high at select", sclk, 1);
                if (exp_q.size() > 0 && exp_q[0].gap >= 0)
                    chk(gap_len == exp_q[0].gap, "R10 list gap", gap_len, exp_q[0].gap);
                in_frame = 1; nbits = 0; hi_len = 1; acc = '0; lo_data = 0;
            end else if (in_frame && !sen_n) begin
                if (!sclk) begin
                    if (p_sclk) begin
                        chk(hi_len == H, "R5 high half length", hi_len, H);
                        lo_len = 1; lo_data = sdata;
                    end else begin
                        lo_len++;
                        chk(sdata == lo_data, "R4 data steady in low", sdata, lo_data);
                    end
                end else if (!p_sclk) begin
                    chk(lo_len == H, "R5 low half length", lo_len, H);
                    chk(sdata == lo_data, "R4 data steady at rise", sdata, lo_data);
                    acc = {acc[14:0], sdata};
                    nbits++; hi_len = 1;
                end else begin
                    hi_len++;
                    if (nbits > 0)
                        chk(sdata == lo_data, "R4 data steady in high", sdata, lo_data);
                end
            end else if (in_frame && sen_n) begin
                in_frame = 0;
                chk(sclk == 1'b1, "R2 clock high at deselect", sclk, 1);
                chk(nbits == 16, "R3 bit count", nbits, 16);
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected frame", acc, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(acc == e.w, e.tag, acc, e.w);
                end
                gap_len = 0;
            end
            if (sen_n) gap_len++;
            p_sen = sen_n; p_sclk = sclk;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sen_n == 1, "R1 select idle", sen_n, 1);
        chk(sclk == 1, "R1 clock idle", sclk, 1);
        chk(busy == 0, "R1 busy idle", busy, 0);
        chk(sdata == 0, "R1 data idle", sdata, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3 / R6: direct writes with assorted patterns
        push(16'hA53C, "R3 word A53C", -1);
        kick(1, 0, 0, 8'hA5, 8'h3C, n);
        chk(n == FRAME, "R6 direct busy length", n, FRAME);
        push(16'h00FF, "R3 word 00FF", -1);
        kick(1, 0, 0, 8'h00, 8'hFF, n);
        push(16'hFF00, "R3 word FF00", -1);
        kick(1, 0, 0, 8'hFF, 8'h00, n);
        push(16'h817E, "R3 word 817E", -1);
        kick(1, 0, 0, 8'h81, 8'h7E, n);
        chk(n == FRAME, "R6 busy length again", n, FRAME);

        // R8 / R10: power-up list
        push(16'h051E, "R8 on step 1", -1);
        push(16'h055E, "R8 on step 2", LIST_GAP);
        push(16'h078D, "R8 on step 3", LIST_GAP);
        push(16'h1301, "R8 on step 4", LIST_GAP);
        push(16'h055F, "R8 on step 5", LIST_GAP);
        kick(0, 1, 0, 8'h00, 8'h00, n);
        chk(n == 5 * (FRAME + 1) + 4 * H, "R10 on list busy", n, 5 * (FRAME + 1) + 4 * H);

        // R9: power-down write
        push(16'h055E, "R9 off write", -1);
        kick(0, 0, 1, 8'h00, 8'h00, n);
        chk(n == FRAME + 1, "R10 off busy", n, FRAME + 1);

        // R7: starts while busy are dropped
        wait_idle();
        push(16'h1234, "R7 only frame", -1);
        req = 1; addr = 8'h12; val = 8'h34;
        @(negedge clk);
        req = 0;
        repeat (10) @(negedge clk);
        req = 1; addr = 8'h55; val = 8'h66; seq_on = 1; seq_off = 1;
        @(negedge clk);
        req = 0; seq_on = 0; seq_off = 0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(busy == 0, "R7 no late start", busy, 0);
        chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

        // R11: priority among simultaneous starts
        push(16'h051E, "R11 on wins 1", -1);
        push(16'h055E, "R11 on wins 2", LIST_GAP);
        push(16'h078D, "R11 on wins 3", LIST_GAP);
        push(16'h1301, "R11 on wins 4", LIST_GAP);
        push(16'h055F, "R11 on wins 5", LIST_GAP);
        wait_idle();
        req = 1; addr = 8'hEE; val = 8'hDD; seq_on = 1; seq_off = 1;
        @(negedge clk);
        req = 0; seq_on = 0; seq_off = 0;
        push(16'h055E, "R11 off beats req", -1);
        kick(1, 0, 1, 8'hEE, 8'hDD, n);
        chk(n == FRAME + 1, "R11 off chosen busy", n, FRAME + 1);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all frames seen", exp_q.size(), 0);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule